// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer

This block is the control sequencer of a small register-based processor. It owns the program counter, the instruction register and the two registers that face memory: an address register and a data register. Every memory transaction goes out through those two registers. Every transaction then waits for a completion input from memory, so memory may take any number of cycles to answer.

For each instruction the sequencer loads the address register from the program counter and reads the instruction word. It moves the word from the data register into the instruction register, advances the program counter by one instruction width, and decodes for one cycle. If the instruction names a memory source, it then fetches that operand. Next it executes on an external ALU. The result is written either to a register or to memory.

The register file and the ALU sit outside the block. The sequencer drives their register selects, the write enable, the operation code and the operand-B source select, and it takes the ALU result back in.

Top module: `fx_sequencer`

## Requirements
- R1: A synchronous reset clears the program counter, the address, data and instruction registers to 0 and forces the fetch phase. In the cycle after reset is released, `mem_rd`, `mem_wr` and `rf_we` are 0 and `mem_addr` is 0.
- R2: An instruction starts with one fetch cycle that copies the program counter into the address register. From the next cycle `mem_rd` is 1 and `mem_addr` equals that program counter value.
- R3: `mem_rd` and `mem_wr` stay at 1 up to and including the cycle in which `mem_mfc` is 1, and they are 0 in the cycle after. While a strobe waits, `mem_addr` and `mem_wdata` hold their values.
- R4: In the cycle after a read completes, the data register is copied into the instruction register and the program counter grows by INSTR_BYTES (4). The next fetch therefore reads the address 4 above the previous one.
- R5: Decode takes exactly one cycle. A register-to-register instruction whose read completes in its first wait cycle takes 5 cycles from fetch to the next fetch.
- R6: When instruction bit 27 (memory source) is 1, decode is followed by one cycle that loads `mem_addr` from the address field, then a read. The returned word is latched into the data register, `mem_wdata` shows it, and `alu_b_mdr` is 1 so that the ALU takes it as operand B.
- R7: When bit 27 is 0, execute follows decode directly. When bit 26 (memory destination) is also 0, `rf_we` is 1 for exactly that one execute cycle and the next cycle is a fetch.
- R8: When bit 26 is 1, execute latches `alu_result` into the data register and the address field into the address register, with no register write. `mem_wr` is then held until completion, and a fetch follows.
- R9: `mem_mfc` and `mem_rdata` have no effect in any cycle in which neither strobe is asserted.
- R10: Instruction fields are: op [31:28] on `alu_op`, destination register [25:22] on `rf_w_sel`, first source [21:18] on `rf_a_sel`, second source [17:14] on `rf_b_sel`, and a zero-extended byte address [13:0]. `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Address register contents |
| mem_wdata | output | DW | Data register contents |
| mem_rdata | input | DW | Word returned by memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_mfc | input | 1 | Memory function complete |
| rf_a_sel | output | RW | Register file read select A |
| rf_b_sel | output | RW | Register file read select B |
| rf_w_sel | output | RW | Register file write select |
| rf_we | output | 1 | Register file write enable |
| alu_op | output | OPW | ALU operation code |
| alu_b_mdr | output | 1 | ALU operand B taken from the data register |
| alu_result | input | DW | ALU result |

## Verification
The hardest situations to reach are a completion that arrives in the very first wait cycle, and a completion pulse that arrives while no strobe is up. The second case must be ignored. The bench memory model gives each access a different latency from zero to three extra cycles. It also raises `mem_mfc` and drives junk on `mem_rdata` during decode, execute and fetch cycles. The program mixes every combination of memory source and memory destination. A reset in the middle of an instruction checks that the sequence restarts from address 0.

// File: rtl/fx_pkg.sv
package fx_pkg;
   typedef enum logic [2:0] {
      PH_FETCH  = 3'd0,
      PH_IWAIT  = 3'd1,
      PH_IRLD   = 3'd2,
      PH_DECODE = 3'd3,
      PH_OADDR  = 3'd4,
      PH_OWAIT  = 3'd5,
      PH_EXEC   = 3'd6,
      PH_STORE  = 3'd7
   } phase_e;
endpackage

// File: rtl/fx_decode.sv
module fx_decode #(
   parameter int DW  = 32,
   parameter int OPW = 4,
   parameter int RW  = 4,
   localparam int AFW = DW - OPW - 2 - 3 * RW
) (
   input  logic [DW-1:0]  ir,
   output logic [OPW-1:0] op,
   output logic           src_mem,
   output logic           dst_mem,
   output logic [RW-1:0]  rd,
   output logic [RW-1:0]  rs1,
   output logic [RW-1:0]  rs2,
   output logic [AFW-1:0] addr_fld
);
   localparam int SM_POS  = DW - OPW - 1;
   localparam int DM_POS  = SM_POS - 1;
   localparam int RD_TOP  = DM_POS - 1;
   localparam int RS1_TOP = RD_TOP - RW;
   localparam int RS2_TOP = RS1_TOP - RW;

   assign op       = ir[DW-1 -: OPW];
   assign src_mem  = ir[SM_POS];
   assign dst_mem  = ir[DM_POS];
   assign rd       = ir[RD_TOP -: RW];
   assign rs1      = ir[RS1_TOP -: RW];
   assign rs2      = ir[RS2_TOP -: RW];
   assign addr_fld = ir[AFW-1:0];
endmodule

// File: rtl/fx_addr_fit.sv
module fx_addr_fit #(
   parameter int AFW = 14,
   parameter int AW  = 16
) (
   input  logic [AFW-1:0] fld,
   output logic [AW-1:0]  addr
);
   generate
      if (AFW >= AW) begin : g_trunc
         assign addr = fld[AW-1:0];
      end else begin : g_zext
         assign addr = {{(AW-AFW){1'b0}}, fld};
      end
   endgenerate
endmodule

// File: rtl/fx_phase_fsm.sv
module fx_phase_fsm
   import fx_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   mfc,
   input  logic   src_mem,
   input  logic   dst_mem,
   output phase_e st_q,
   output logic   mar_from_pc,
   output logic   mar_from_ir,
   output logic   mdr_from_mem,
   output logic   mdr_from_alu,
   output logic   ir_load,
   output logic   pc_step,
   output logic   rd_strobe,
   output logic   wr_strobe,
   output logic   reg_write
);
   phase_e st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         PH_FETCH:  st_d = PH_IWAIT;
         PH_IWAIT:  if (mfc) st_d = PH_IRLD;
         PH_IRLD:   st_d = PH_DECODE;
         PH_DECODE: st_d = src_mem ? PH_OADDR : PH_EXEC;
         PH_OADDR:  st_d = PH_OWAIT;
         PH_OWAIT:  if (mfc) st_d = PH_EXEC;
         PH_EXEC:   st_d = dst_mem ? PH_STORE : PH_FETCH;
         PH_STORE:  if (mfc) st_d = PH_FETCH;
         default:   st_d = PH_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= PH_FETCH;
      else     st_q <= st_d;
   end

   assign rd_strobe    = (st_q == PH_IWAIT) || (st_q == PH_OWAIT);
   assign wr_strobe    = (st_q == PH_STORE);
   assign mar_from_pc  = (st_q == PH_FETCH);
   assign mar_from_ir  = (st_q == PH_OADDR) || ((st_q == PH_EXEC) && dst_mem);
   assign mdr_from_mem = rd_strobe && mfc;
   assign mdr_from_alu = (st_q == PH_EXEC) && dst_mem;
   assign ir_load      = (st_q == PH_IRLD);
   assign pc_step      = (st_q == PH_IRLD);
   assign reg_write    = (st_q == PH_EXEC) && !dst_mem;
endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer #(
   parameter int DW          = 32,
   parameter int AW          = 16,
   parameter int OPW         = 4,
   parameter int RW          = 4,
   parameter int INSTR_BYTES = 4
) (
   input  logic           clk,
   input  logic           rst,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   output logic           mem_rd,
   output logic           mem_wr,
   input  logic           mem_mfc,
   output logic [RW-1:0]  rf_a_sel,
   output logic [RW-1:0]  rf_b_sel,
   output logic [RW-1:0]  rf_w_sel,
   output logic           rf_we,
   output logic [OPW-1:0] alu_op,
   output logic           alu_b_mdr,
   input  logic [DW-1:0]  alu_result
);
   import fx_pkg::*;

   localparam int AFW = DW - OPW - 2 - 3 * RW;
   localparam logic [AW-1:0] PC_INC = AW'(INSTR_BYTES);

   generate
      if (AFW < 1) begin : g_bad_fields
         $error("fx_sequencer: DW too small for the opcode and register fields");
      end
      if (AW < 2) begin : g_bad_aw
         $error("fx_sequencer: AW must be at least 2");
      end
      if (INSTR_BYTES < 1) begin : g_bad_step
         $error("fx_sequencer: INSTR_BYTES must be positive");
      end
   endgenerate

   logic [AW-1:0]  pc_q, mar_q;
   logic [DW-1:0]  mdr_q, ir_q;
   logic [AFW-1:0] addr_fld;
   logic [AW-1:0]  opnd_addr;
   logic           src_mem, dst_mem;
   logic           mar_from_pc, mar_from_ir, mdr_from_mem, mdr_from_alu;
   logic           ir_load, pc_step;
   phase_e         st_q;

   fx_decode #(.DW(DW), .OPW(OPW), .RW(RW)) u_dec (
      .ir(ir_q), .op(alu_op), .src_mem(src_mem), .dst_mem(dst_mem),
      .rd(rf_w_sel), .rs1(rf_a_sel), .rs2(rf_b_sel), .addr_fld(addr_fld)
   );

   fx_addr_fit #(.AFW(AFW), .AW(AW)) u_fit (.fld(addr_fld), .addr(opnd_addr));

   fx_phase_fsm u_fsm (
      .clk(clk), .rst(rst), .mfc(mem_mfc), .src_mem(src_mem), .dst_mem(dst_mem),
      .st_q(st_q), .mar_from_pc(mar_from_pc), .mar_from_ir(mar_from_ir),
      .mdr_from_mem(mdr_from_mem), .mdr_from_alu(mdr_from_alu),
      .ir_load(ir_load), .pc_step(pc_step),
      .rd_strobe(mem_rd), .wr_strobe(mem_wr), .reg_write(rf_we)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
         ir_q  <= '0;
      end else begin
         if (mar_from_pc)       mar_q <= pc_q;
         else if (mar_from_ir)  mar_q <= opnd_addr;
         if (mdr_from_mem)      mdr_q <= mem_rdata;
         else if (mdr_from_alu) mdr_q <= alu_result;
         if (ir_load)           ir_q  <= mdr_q;
         if (pc_step)           pc_q  <= pc_q + PC_INC;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;
   assign alu_b_mdr = src_mem;
endmodule

// File: rtl/fx_sequencer_chk.sv
module fx_sequencer_chk #(
   parameter int DW          = 32,
   parameter int AW          = 16,
   parameter int INSTR_BYTES = 4
) (
   input logic           clk,
   input logic           rst,
   input logic           mem_rd,
   input logic           mem_wr,
   input logic           mem_mfc,
   input logic [AW-1:0]  mem_addr,
   input logic [DW-1:0]  mem_wdata,
   input logic           rf_we,
   input logic [AW-1:0]  pc,
   input fx_pkg::phase_e st
);
   import fx_pkg::*;

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && !mem_mfc) |=> mem_rd);                                  // R3
   AST_RD_DROP: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && mem_mfc) |=> !mem_rd);                                  // R3
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && !mem_mfc) |=> mem_wr);                                  // R3
   AST_WR_DROP: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && mem_mfc) |=> !mem_wr);                                  // R3
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
      ((mem_rd || mem_wr) && !mem_mfc) |=> $stable(mem_addr));           // R3
   AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && !mem_mfc) |=> $stable(mem_wdata));                      // R3
   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (st == PH_IRLD) |=> (pc == $past(pc) + AW'(INSTR_BYTES)));         // R4
   AST_DECODE_ONCE: assert property (@(posedge clk) disable iff (rst)
      (st == PH_DECODE) |=> (st != PH_DECODE));                          // R5
   AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
      rf_we |=> !rf_we);                                                 // R7
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));                                              // R10
endmodule

bind fx_sequencer fx_sequencer_chk #(.DW(DW), .AW(AW), .INSTR_BYTES(INSTR_BYTES)) u_chk (
   .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_mfc(mem_mfc),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rf_we(rf_we), .pc(pc_q), .st(st_q)
);

// File: tb/test_fx_sequencer.sv
`timescale 1ns/1ps
module test_fx_sequencer;
   localparam int DW = 32;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_rd, mem_wr;
   logic          mem_mfc = 1'b0;
   logic [3:0]    rf_a_sel, rf_b_sel, rf_w_sel;
   logic          rf_we;
   logic [3:0]    alu_op;
   logic          alu_b_mdr;
   logic [DW-1:0] alu_result;

   always #4 clk = ~clk;

   fx_sequencer i_fx_sequencer (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_mfc(mem_mfc),
      .rf_a_sel(rf_a_sel), .rf_b_sel(rf_b_sel), .rf_w_sel(rf_w_sel), .rf_we(rf_we),
      .alu_op(alu_op), .alu_b_mdr(alu_b_mdr), .alu_result(alu_result)
   );

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [128];
   logic [31:0] rf  [16];

   // model state: 0 fetch,1 instr wait,2 ir load,3 decode,4 opnd addr,5 opnd wait,6 exec,7 store
   int          ph;
   logic [15:0] m_pc, m_mar;
   logic [31:0] m_mdr, m_ir;
   int          wait_n, acc_n;

   function automatic logic [31:0] falu(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      case (op)
         4'd0: return a + b;
         4'd1: return a - b;
         4'd2: return a & b;
         4'd3: return a | b;
         4'd4: return a ^ b;
         default: return a;
      endcase
   endfunction

   function automatic logic [31:0] enc(input int op, input int sm, input int dm,
                                       input int rd, input int rs1, input int rs2, input int adr);
      return {op[3:0], sm[0], dm[0], rd[3:0], rs1[3:0], rs2[3:0], adr[13:0]};
   endfunction

   always_comb alu_result = falu(alu_op, rf[rf_a_sel], alu_b_mdr ? mem_wdata : rf[rf_b_sel]);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      ph = 0; m_pc = '0; m_mar = '0; m_mdr = '0; m_ir = '0; wait_n = 0;
   endtask

   task automatic step(input int cyc, input bit do_rst);
      bit e_rd, e_wr, e_we, mfc;
      int lat;
      e_rd = (ph == 1) || (ph == 5);
      e_wr = (ph == 7);
      e_we = (ph == 6) && !m_ir[26];
      chk("R3 R9 mem_rd", 32'(mem_rd), 32'(e_rd));
      chk("R3 R8 mem_wr", 32'(mem_wr), 32'(e_wr));
      chk("R2 R4 R6 mem_addr", 32'(mem_addr), 32'(m_mar));
      chk("R6 R8 mem_wdata", mem_wdata, m_mdr);
      chk("R5 R7 rf_we", 32'(rf_we), 32'(e_we));
      chk("R6 alu_b_mdr", 32'(alu_b_mdr), 32'(m_ir[27]));
      chk("R10 alu_op", 32'(alu_op), 32'(m_ir[31:28]));
      chk("R10 rf_a_sel", 32'(rf_a_sel), 32'(m_ir[21:18]));
      chk("R10 rf_b_sel", 32'(rf_b_sel), 32'(m_ir[17:14]));
      chk("R10 rf_w_sel", 32'(rf_w_sel), 32'(m_ir[25:22]));
      if (ph == 1) chk("R2 R4 fetch address", 32'(mem_addr), 32'(m_pc));
      // memory response for this cycle
      if (do_rst) begin
         mfc = 1'b0;
      end else if (e_rd || e_wr) begin
         lat = (acc_n * 5 + 1) % 4;
         if (wait_n >= lat) begin mfc = 1'b1; wait_n = 0; acc_n++; end
         else begin mfc = 1'b0; wait_n++; end
      end else begin
         mfc = (cyc % 3 == 0);   // R9 stray completion
      end
      mem_mfc   = mfc;
      mem_rdata = e_rd ? mem[m_mar[8:2]] : (32'hDEAD_BEEF ^ 32'(cyc));
      rst       = do_rst;
      // advance model to the state after the coming edge
      if (do_rst) begin
         model_reset();
      end else begin
         case (ph)
            0: begin m_mar = m_pc; ph = 1; end
            1: if (mfc) begin m_mdr = mem[m_mar[8:2]]; ph = 2; end
            2: begin m_ir = m_mdr; m_pc = m_pc + 16'd4; ph = 3; end
            3: ph = m_ir[27] ? 4 : 6;
            4: begin m_mar = {2'b00, m_ir[13:0]}; ph = 5; end
            5: if (mfc) begin m_mdr = mem[m_mar[8:2]]; ph = 6; end
            6: begin
               if (m_ir[26]) begin
                  m_mdr = falu(m_ir[31:28], rf[m_ir[21:18]], m_ir[27] ? m_mdr : rf[m_ir[17:14]]);
                  m_mar = {2'b00, m_ir[13:0]};
                  ph = 7;
               end else begin
                  rf[m_ir[25:22]] = falu(m_ir[31:28], rf[m_ir[21:18]], m_ir[27] ? m_mdr : rf[m_ir[17:14]]);
                  ph = 0;
               end
            end
            7: if (mfc) begin mem[m_mar[8:2]] = m_mdr; ph = 0; end
            default: ph = 0;
         endcase
      end
   endtask

   bit done = 1'b0;

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = '0;
      for (int i = 0; i < 16; i++) rf[i] = 32'h0101_0101 * i + 32'd7;
      mem[0] = enc(0, 0, 0, 1, 2, 3, 0);        // reg + reg -> reg
      mem[1] = enc(4, 1, 0, 4, 5, 0, 'h100);    // reg ^ mem -> reg
      mem[2] = enc(1, 0, 1, 0, 6, 7, 'h104);    // reg - reg -> mem
      mem[3] = enc(0, 1, 1, 0, 1, 0, 'h108);    // reg + mem -> mem
      mem[4] = enc(3, 0, 0, 8, 1, 4, 0);
      mem[5] = enc(2, 1, 0, 9, 8, 0, 'h104);
      mem[6] = enc(0, 1, 1, 0, 9, 0, 'h10C);
      mem[7] = enc(5, 0, 0, 10, 9, 2, 0);
      mem[64] = 32'h0F0F_1234;
      mem[66] = 32'h0000_0100;
      mem[67] = 32'h1111_2222;
      acc_n = 0;
      model_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 mem_rd after reset", 32'(mem_rd), 32'd0);
      chk("R1 mem_wr after reset", 32'(mem_wr), 32'd0);
      chk("R1 mem_addr after reset", 32'(mem_addr), 32'd0);
      chk("R1 rf_we after reset", 32'(rf_we), 32'd0);
      chk("R1 mem_wdata after reset", mem_wdata, 32'd0);
      for (int cyc = 0; cyc < 900; cyc++) begin
         if (cyc > 0) @(negedge clk);
         step(cyc, (cyc == 403) || (cyc == 404));
      end
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule